// File: doc/BRIEF.md
# Backlight PWM Generator with Buffered Timing

This block produces a single pulse-width-modulated output meant to dim a display backlight. Software programs it through a plain register write port. The clock is first divided by a programmable prescaler. A period counter then counts prescaled ticks. The output is high for a programmable number of ticks at the start of every period.

Software never writes the counting logic directly. It writes the prescaler, period and high-width values into shadow registers. Those values are copied into the active set in one of two ways:

- When software raises a commit bit in the control register. While the block is running, the copy waits for the end of the current period. While it is stopped, the copy is made at once.
- In manual mode, at every period boundary, with no commit needed.

Either way, a period in progress always runs to completion with the settings it started with. Every register reads back the shadow contents.

Top module: `bl_pwm`

## Requirements
- R1: After reset, `pwm_o` is low and all three registers read back as zero.
- R2: Register map. Offset 0x0 is control: bit 0 enable, bit 1 manual mode, bit 2 commit. Offset 0x4 holds the prescaler divisor in bits [25:16]. Offset 0x8 holds the period in bits [11:0] and the high width in bits [28:16]. A write stores only these fields, and all other bits read as zero.
- R3: While enabled, one output period lasts (div+1)*(period+1) clock cycles. The first period begins in the cycle after the edge that stores enable=1.
- R4: Each period opens with min((div+1)*high, (div+1)*(period+1)) high cycles, and the output is low for the rest of the period. A high width of 0 keeps the output low. A high width of period+1 or more keeps it high.
- R5: Shadow writes do not change the output waveform until a commit or manual mode moves them into the active set.
- R6: A 0-to-1 change of the stored commit bit while running takes effect at the next period boundary. The period in progress finishes with the old values.
- R7: A commit made while disabled loads the active set at once, so the next enable runs with the new values.
- R8: With manual mode set, the shadow values are loaded at every period boundary without any commit.
- R9: While disabled, `pwm_o` is low and both counters are held at zero. Enabling again restarts at the beginning of a period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_stb | input | 1 | One-cycle write strobe |
| wr_addr | input | ADDR_W | Write byte offset |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Read byte offset |
| rd_data | output | DATA_W | Shadow register contents at rd_addr |
| pwm_o | output | 1 | PWM output |

## Verification
The bench builds the block with its default widths: a 10-bit divisor, a 12-bit period and a 13-bit high width. The field positions and the full-width readback masks are therefore checked exactly as specified. The bench keeps divisor and period values small, so each period is only a few cycles long. This lets it compare the output cycle by cycle over whole periods for each table entry. It also lets it place commits, shadow writes and disables at chosen phases within a period, so that loading only at the boundary can be observed directly.

// File: rtl/bl_pwm_pkg.sv
package bl_pwm_pkg;
    // Register byte offsets
    localparam logic [3:0] OFS_CTRL = 4'h0;
    localparam logic [3:0] OFS_DIV  = 4'h4;
    localparam logic [3:0] OFS_TIME = 4'h8;
    // Control bit positions
    localparam int BIT_EN     = 0;
    localparam int BIT_MANUAL = 1;
    localparam int BIT_COMMIT = 2;
    // Field positions inside the divisor and timing registers
    localparam int DIV_LSB  = 16;
    localparam int PER_LSB  = 0;
    localparam int HIGH_LSB = 16;
endpackage

// File: rtl/bl_pwm_regs.sv
module bl_pwm_regs
    import bl_pwm_pkg::*;
#(
    parameter int DIV_W  = 10,
    parameter int PER_W  = 12,
    parameter int HIGH_W = 13,
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              en,
    output logic              manual,
    output logic              commit_pulse,
    output logic [DIV_W-1:0]  sh_div,
    output logic [PER_W-1:0]  sh_per,
    output logic [HIGH_W-1:0] sh_high
);
    typedef struct packed {
        logic              en;
        logic              manual;
        logic              commit;
        logic              pulse;
        logic [DIV_W-1:0]  div;
        logic [PER_W-1:0]  per;
        logic [HIGH_W-1:0] high;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d       = regs_q;
        regs_d.pulse = 1'b0;
        if (wr_stb) begin
            case (wr_addr)
                ADDR_W'(OFS_CTRL): begin
                    regs_d.en     = wr_data[BIT_EN];
                    regs_d.manual = wr_data[BIT_MANUAL];
                    regs_d.commit = wr_data[BIT_COMMIT];
                    regs_d.pulse  = wr_data[BIT_COMMIT] & ~regs_q.commit;
                end
                ADDR_W'(OFS_DIV):  regs_d.div = wr_data[DIV_LSB +: DIV_W];
                ADDR_W'(OFS_TIME): begin
                    regs_d.per  = wr_data[PER_LSB +: PER_W];
                    regs_d.high = wr_data[HIGH_LSB +: HIGH_W];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            ADDR_W'(OFS_CTRL): begin
                rd_data[BIT_EN]     = regs_q.en;
                rd_data[BIT_MANUAL] = regs_q.manual;
                rd_data[BIT_COMMIT] = regs_q.commit;
            end
            ADDR_W'(OFS_DIV):  rd_data[DIV_LSB +: DIV_W] = regs_q.div;
            ADDR_W'(OFS_TIME): begin
                rd_data[PER_LSB +: PER_W]   = regs_q.per;
                rd_data[HIGH_LSB +: HIGH_W] = regs_q.high;
            end
            default: ;
        endcase
    end

    assign en           = regs_q.en;
    assign manual       = regs_q.manual;
    assign commit_pulse = regs_q.pulse;
    assign sh_div       = regs_q.div;
    assign sh_per       = regs_q.per;
    assign sh_high      = regs_q.high;
endmodule

// File: rtl/bl_pwm_core.sv
module bl_pwm_core #(
    parameter int DIV_W  = 10,
    parameter int PER_W  = 12,
    parameter int HIGH_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              manual,
    input  logic              commit_pulse,
    input  logic [DIV_W-1:0]  sh_div,
    input  logic [PER_W-1:0]  sh_per,
    input  logic [HIGH_W-1:0] sh_high,
    output logic              pwm_o
);
    localparam int CMP_W = (HIGH_W > PER_W) ? HIGH_W : PER_W;

    typedef struct packed {
        logic              pending;
        logic [DIV_W-1:0]  pre;
        logic [PER_W-1:0]  per;
        logic [DIV_W-1:0]  div;
        logic [PER_W-1:0]  prd;
        logic [HIGH_W-1:0] high;
    } core_t;

    core_t core_d, core_q;

    logic [DIV_W-1:0]  pre_cnt;
    logic [PER_W-1:0]  per_cnt;
    logic [DIV_W-1:0]  act_div;
    logic [PER_W-1:0]  act_per;
    logic [HIGH_W-1:0] act_high;

    assign pre_cnt  = core_q.pre;
    assign per_cnt  = core_q.per;
    assign act_div  = core_q.div;
    assign act_per  = core_q.prd;
    assign act_high = core_q.high;

    always_comb begin
        logic tick_wrap;
        logic boundary;
        logic want;
        logic take;
        core_d    = core_q;
        tick_wrap = (pre_cnt == act_div);
        boundary  = tick_wrap && (per_cnt == act_per);
        want      = core_q.pending | commit_pulse;
        take      = (want | manual) & (~en | boundary);

        if (en) begin
            if (tick_wrap) begin
                core_d.pre = '0;
                core_d.per = boundary ? '0 : per_cnt + 1'b1;
            end else begin
                core_d.pre = pre_cnt + 1'b1;
            end
        end else begin
            core_d.pre = '0;
            core_d.per = '0;
        end

        core_d.pending = want & ~take;
        if (take) begin
            core_d.div  = sh_div;
            core_d.prd  = sh_per;
            core_d.high = sh_high;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) core_q <= '0;
        else        core_q <= core_d;
    end

    assign pwm_o = en & (CMP_W'(per_cnt) < CMP_W'(act_high));
endmodule

// File: rtl/bl_pwm.sv
module bl_pwm #(
    parameter int DIV_W  = 10,
    parameter int PER_W  = 12,
    parameter int HIGH_W = 13,
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              pwm_o
);
    logic              en;
    logic              manual;
    logic              commit_pulse;
    logic [DIV_W-1:0]  sh_div;
    logic [PER_W-1:0]  sh_per;
    logic [HIGH_W-1:0] sh_high;

    bl_pwm_regs #(
        .DIV_W(DIV_W), .PER_W(PER_W), .HIGH_W(HIGH_W),
        .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) i_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .en(en), .manual(manual), .commit_pulse(commit_pulse),
        .sh_div(sh_div), .sh_per(sh_per), .sh_high(sh_high)
    );

    bl_pwm_core #(
        .DIV_W(DIV_W), .PER_W(PER_W), .HIGH_W(HIGH_W)
    ) i_core (
        .clk(clk), .rst_n(rst_n),
        .en(en), .manual(manual), .commit_pulse(commit_pulse),
        .sh_div(sh_div), .sh_per(sh_per), .sh_high(sh_high),
        .pwm_o(pwm_o)
    );
endmodule

// File: rtl/bl_pwm_chk.sv
module bl_pwm_chk #(
    parameter int DIV_W  = 10,
    parameter int PER_W  = 12,
    parameter int HIGH_W = 13
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en,
    input logic              pwm_o,
    input logic [DIV_W-1:0]  pre_cnt,
    input logic [PER_W-1:0]  per_cnt,
    input logic [DIV_W-1:0]  act_div,
    input logic [PER_W-1:0]  act_per,
    input logic [HIGH_W-1:0] act_high
);
    logic at_end;
    assign at_end = (pre_cnt == act_div) && (per_cnt == act_per);

    // R3: counters never pass their active limits
    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_cnt <= act_div) && (per_cnt <= act_per));

    // R3: the period counter moves only when the prescaler wraps
    p_per_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        en && (pre_cnt != act_div) |=> $stable(per_cnt));

    // R6: active values change only at a boundary while running
    p_act_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        en && !at_end |=> $stable(act_div) && $stable(act_per) && $stable(act_high));

    // R4: zero high width keeps the output low
    p_zero_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (act_high == '0) |-> !pwm_o);

    // R9: counters return to zero once disabled
    p_off_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (pre_cnt == '0) && (per_cnt == '0));
endmodule

bind bl_pwm_core bl_pwm_chk #(
    .DIV_W(DIV_W), .PER_W(PER_W), .HIGH_W(HIGH_W)
) i_bl_pwm_chk (
    .clk(clk), .rst_n(rst_n), .en(en), .pwm_o(pwm_o),
    .pre_cnt(pre_cnt), .per_cnt(per_cnt),
    .act_div(act_div), .act_per(act_per), .act_high(act_high)
);

// File: tb/test_bl_pwm.sv
module test_bl_pwm;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_stb = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [3:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        pwm_o;

    int n_run = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bl_pwm i_bl_pwm (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .pwm_o(pwm_o)
    );

    typedef struct packed {
        int d; int p; int h; int prd; int hi;
    } vec_t;

    // divisor, period, high width, expected period cycles, expected high cycles
    localparam vec_t VEC [8] = '{
        '{0, 3, 2, 4, 2},
        '{1, 4, 3, 10, 6},
        '{2, 2, 1, 9, 3},
        '{0, 5, 0, 6, 0},
        '{0, 3, 4, 4, 4},
        '{0, 3, 9, 4, 4},
        '{3, 1, 1, 8, 4},
        '{0, 0, 1, 1, 1}
    };

    task automatic check(input string req, input string what,
                         input longint act, input longint exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic step(input logic stb, input logic [3:0] a,
                        input logic [31:0] d, output logic s);
        s       = pwm_o;
        wr_stb  = stb;
        wr_addr = a;
        wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_stb = 1'b0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        logic s;
        step(1'b1, a, d, s);
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic load_cfg(input int d, input int p, input int h);
        wr(4'h0, 32'h0);
        wr(4'h4, 32'(d) << 16);
        wr(4'h8, (32'(h) << 16) | 32'(p));
        wr(4'h0, 32'h4);
        wr(4'h0, 32'h0);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] r;
        logic        s;
        logic        smp [0:19];
        int          bad;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1", "pwm after reset", longint'(pwm_o), 0);
        rd(4'h0, r); check("R1", "ctrl after reset", r, 0);
        rd(4'h4, r); check("R1", "div after reset", r, 0);
        rd(4'h8, r); check("R1", "time after reset", r, 0);

        // R2: field masks and readback
        wr(4'h4, 32'hFFFF_FFFF);
        rd(4'h4, r); check("R2", "div readback", r, 32'h03FF_0000);
        wr(4'h8, 32'hFFFF_FFFF);
        rd(4'h8, r); check("R2", "time readback", r, 32'h1FFF_0FFF);
        wr(4'h0, 32'hFFFF_FFFB);
        rd(4'h0, r); check("R2", "ctrl readback", r, 32'h3);
        wr(4'h0, 32'h0);

        // R3 R4 R7: table of settings, each committed while stopped
        foreach (VEC[i]) begin
            load_cfg(VEC[i].d, VEC[i].p, VEC[i].h);
            wr(4'h0, 32'h1);
            bad = 0;
            for (int k = 0; k < 2 * VEC[i].prd; k++) begin
                step(1'b0, 4'h0, 32'h0, s);
                if (s !== ((k % VEC[i].prd) < VEC[i].hi)) bad++;
            end
            check("R3 R4 R7", $sformatf("waveform mismatches, vector %0d", i), bad, 0);
        end

        // R5 R6: shadow write while running, then commit mid-period
        load_cfg(0, 3, 1);
        wr(4'h0, 32'h1);
        for (int k = 0; k < 20; k++) begin
            if (k == 5)       step(1'b1, 4'h8, (32'd2 << 16) | 32'd1, smp[k]);
            else if (k == 12) step(1'b1, 4'h0, 32'h5, smp[k]);
            else if (k == 13) step(1'b1, 4'h0, 32'h1, smp[k]);
            else              step(1'b0, 4'h0, 32'h0, smp[k]);
        end
        bad = 0;
        for (int k = 0; k < 12; k++) if (smp[k] !== (k % 4 == 0)) bad++;
        check("R5", "uncommitted shadow changed output", bad, 0);
        check("R6", "commit pattern", {smp[12], smp[13], smp[14], smp[15],
              smp[16], smp[17], smp[18], smp[19]}, 8'b1000_1111);

        // R8: manual mode picks up shadow at boundary
        load_cfg(0, 3, 1);
        wr(4'h0, 32'h3);
        for (int k = 0; k < 8; k++) begin
            if (k == 1) step(1'b1, 4'h8, (32'd1 << 16) | 32'd1, smp[k]);
            else        step(1'b0, 4'h0, 32'h0, smp[k]);
        end
        check("R8", "manual pattern", {smp[0], smp[1], smp[2], smp[3],
              smp[4], smp[5], smp[6], smp[7]}, 8'b1000_1010);

        // R9: disable mid-period, then restart
        load_cfg(0, 3, 2);
        wr(4'h0, 32'h1);
        for (int k = 0; k < 12; k++) begin
            if (k == 2)      step(1'b1, 4'h0, 32'h0, smp[k]);
            else if (k == 7) step(1'b1, 4'h0, 32'h1, smp[k]);
            else             step(1'b0, 4'h0, 32'h0, smp[k]);
        end
        check("R9", "low while disabled", {smp[3], smp[4], smp[5], smp[6], smp[7]}, 0);
        check("R9", "restart pattern", {smp[8], smp[9], smp[10], smp[11]}, 4'b1100);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule